// File: doc/BRIEF.md
# Nine-bit address-detect serial receiver

This block receives asynchronous serial frames on a multidrop line. Each frame carries eight data bits and a ninth flag bit. A set flag marks the word as an address, and a clear flag marks it as data. The line is oversampled at sixteen times the bit rate. Each bit is decided by a majority vote over three samples taken around the middle of the bit.

When attention mode is off, every well-formed word is delivered to the buffer. When attention mode is on, only address words raise the attention interrupt. Software reads the buffered address and then sets or clears an accept control. That control decides whether the data words that follow reach the buffer or are discarded silently.

A missing stop bit is reported as a framing error, and the word is discarded. A word that is stored while the previous one is still unread sets a sticky overrun flag. A read strobe clears both the buffer-full condition and the overrun flag.

Top module: `uart9_addr_rx`

## Requirements
- R1: Frame format on rx_i: a low start bit, eight data bits sent least significant first, the flag bit, and a high stop bit, each bit lasting 16 clk_i cycles. A stored word appears on rx_word_o with the data in bits [7:0] and the flag in bit 8. The word is marked by a one-cycle rx_valid_o pulse on the 173rd rising clk_i edge after the start-bit falling edge is applied.
- R2: Each bit is decided by a majority of its samples 7, 8 and 9, counted from 0. A wrong level on a single one of those samples does not change the received word.
- R3: A low pulse on an idle line whose majority at samples 7 to 9 is high is a false start. It produces no output, and the receiver is ready for the next start edge.
- R4: With attn_en_i high, a word whose flag is 1 is stored. attn_irq_o pulses in the same cycle as rx_valid_o.
- R5: With attn_en_i high and accept_data_i low, a word whose flag is 0 is dropped. Neither rx_valid_o nor attn_irq_o rises, and rx_word_o and overrun_o keep their values.
- R6: With attn_en_i high and accept_data_i high, a data word (flag 0) is stored with rx_valid_o and without attn_irq_o.
- R7: With attn_en_i low, every well-formed word is stored with rx_valid_o, whatever its flag, and attn_irq_o never rises.
- R8: A stop bit decided low gives a one-cycle frame_err_o pulse at the cycle where rx_valid_o would have risen. There is no rx_valid_o pulse, and rx_word_o is unchanged.
- R9: Storing a word while the previous stored word has not been read (no rd_i since it was stored) sets overrun_o in the storing cycle. The new word replaces the old one. overrun_o stays high until an rd_i cycle, which clears it.
- R10: An rd_i pulse in the same cycle a word is stored counts as reading the old word first. overrun_o does not rise, and the new word becomes the unread word.
- R11: While rst_ni is low, rx_word_o, rx_valid_o, attn_irq_o, frame_err_o and overrun_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 16 cycles per bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| attn_en_i | input | 1 | Attention mode enable |
| accept_data_i | input | 1 | Software accept control for data words in attention mode |
| rd_i | input | 1 | Buffer read strobe, clears full and overrun |
| rx_word_o | output | 9 | Receive buffer, flag in bit 8 |
| rx_valid_o | output | 1 | One-cycle strobe when a word is stored |
| attn_irq_o | output | 1 | One-cycle address interrupt in attention mode |
| frame_err_o | output | 1 | One-cycle framing error strobe |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The cycle where a word is stored and the cycle where software reads the buffer can coincide. The result then depends on whether the read is taken before or after the store. The bench provokes this by raising rd_i exactly in the completion cycle of a frame while the buffer already holds an unread word. A behavioural model applies the read first and then the store, and it expects overrun_o to stay low with the new word held as unread. A later frame without a read must then raise overrun_o, which shows that the coincident read left the new word counted as unread.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } rx_state_e;
endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
  parameter int    STAGES    = 2,
  parameter logic  RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart9_deframer.sv
module uart9_deframer
  import uart9_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_s_i,
  output logic            done_o,
  output logic            stop_ok_o,
  output logic [DATA_W:0] word_o
);
  localparam int BITS  = DATA_W + 3;          // start, data, flag, stop
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(BITS);
  localparam int MID   = OSR / 2;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              s_a_q, s_b_q;
  logic [DATA_W:0]   shreg_q;
  logic              maj;

  assign maj    = (s_a_q & s_b_q) | (s_a_q & rx_s_i) | (s_b_q & rx_s_i);
  assign word_o = shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      s_a_q     <= 1'b1;
      s_b_q     <= 1'b1;
      shreg_q   <= '0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_s_i) begin
            state_q <= ST_ACTIVE;
            idx_q   <= '0;
            cnt_q   <= CNT_W'(1);
          end
        end
        ST_ACTIVE: begin
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (cnt_q == CNT_W'(MID - 1)) s_a_q <= rx_s_i;
          if (cnt_q == CNT_W'(MID))     s_b_q <= rx_s_i;
          if (cnt_q == CNT_W'(MID + 1)) begin
            if (idx_q == '0) begin
              if (maj) state_q <= ST_IDLE;   // false start
            end else if (idx_q == IDX_W'(BITS - 1)) begin
              done_o    <= 1'b1;
              stop_ok_o <= maj;
              state_q   <= ST_IDLE;
            end else begin
              shreg_q <= {maj, shreg_q[DATA_W:1]};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rx_s_i) |=> (state_q == ST_IDLE && !done_o));

  p_word_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> $stable(word_o));
endmodule

// File: rtl/uart9_attn_filter.sv
module uart9_attn_filter #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              stop_ok_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              attn_en_i,
  input  logic              accept_data_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              attn_irq_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  localparam int FLAG_BIT = WORD_W - 1;

  logic is_addr, drop, store, full_q;

  assign is_addr = word_i[FLAG_BIT];
  assign drop    = attn_en_i && !is_addr && !accept_data_i;
  assign store   = done_i && stop_ok_i && !drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_word_o   <= '0;
      rx_valid_o  <= 1'b0;
      attn_irq_o  <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
      full_q      <= 1'b0;
    end else begin
      rx_valid_o  <= store;
      attn_irq_o  <= store && attn_en_i && is_addr;
      frame_err_o <= done_i && !stop_ok_i;
      if (store) begin
        rx_word_o <= word_i;
        full_q    <= 1'b1;
        // a coincident read retires the old word first
        overrun_o <= rd_i ? 1'b0 : (overrun_o | full_q);
      end else if (rd_i) begin
        full_q    <= 1'b0;
        overrun_o <= 1'b0;
      end
    end
  end

  p_irq_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_irq_o |-> (rx_valid_o && rx_word_o[FLAG_BIT]));

  p_drop_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && attn_en_i && !word_i[FLAG_BIT] && !accept_data_i) |=> (!rx_valid_o && $stable(rx_word_o)));

  p_no_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !attn_en_i) |=> !attn_irq_o);

  p_ferr_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (!rx_valid_o && !attn_irq_o));

  p_overrun_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> rx_valid_o);

  p_rd_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !overrun_o);
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          attn_en_i,
  input  logic          accept_data_i,
  input  logic          rd_i,
  output logic [DATA_W:0] rx_word_o,
  output logic          rx_valid_o,
  output logic          attn_irq_o,
  output logic          frame_err_o,
  output logic          overrun_o
);
  localparam int WORD_W = DATA_W + 1;

  logic              rx_s;
  logic              done, stop_ok;
  logic [WORD_W-1:0] word;

  uart9_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart9_deframer #(.OSR(OSR), .DATA_W(DATA_W)) i_deframer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_s_i   (rx_s),
    .done_o   (done),
    .stop_ok_o(stop_ok),
    .word_o   (word)
  );

  uart9_attn_filter #(.WORD_W(WORD_W)) i_filter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (done),
    .stop_ok_i    (stop_ok),
    .word_i       (word),
    .attn_en_i    (attn_en_i),
    .accept_data_i(accept_data_i),
    .rd_i         (rd_i),
    .rx_word_o    (rx_word_o),
    .rx_valid_o   (rx_valid_o),
    .attn_irq_o   (attn_irq_o),
    .frame_err_o  (frame_err_o),
    .overrun_o    (overrun_o)
  );

  p_reset_quiet_r11: assert property (@(posedge clk_i)
    !rst_ni |-> (!rx_valid_o && !attn_irq_o && !frame_err_o && !overrun_o));
endmodule

// File: tb/test_uart9_addr_rx.sv
module test_uart9_addr_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       attn_en_i = 1'b0;
  logic       accept_data_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [8:0] rx_word_o;
  logic       rx_valid_o, attn_irq_o, frame_err_o, overrun_o;

  uart9_addr_rx i_uart9_addr_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .attn_en_i(attn_en_i),
    .accept_data_i(accept_data_i), .rd_i(rd_i), .rx_word_o(rx_word_o),
    .rx_valid_o(rx_valid_o), .attn_irq_o(attn_irq_o),
    .frame_err_o(frame_err_o), .overrun_o(overrun_o)
  );

  always #5 clk_i = ~clk_i;

  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_req = "R11";

  // pending frames: completion cycle, word, stop level
  int         q_due[$];
  logic [8:0] q_word[$];
  logic       q_stop[$];

  // behavioural model state
  logic [8:0] m_word = '0;
  logic       m_full = 0, m_ovr = 0;

  always @(posedge clk_i) begin
    logic e_valid, e_irq, e_ferr;
    #1;
    cyc++;
    e_valid = 0; e_irq = 0; e_ferr = 0;
    if (!rst_ni) begin
      m_word = '0; m_full = 0; m_ovr = 0;
    end else begin
      if (rd_i) begin m_full = 0; m_ovr = 0; end
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        logic [8:0] w; logic s;
        void'(q_due.pop_front());
        w = q_word.pop_front();
        s = q_stop.pop_front();
        if (!s) e_ferr = 1;
        else if (attn_en_i && !w[8] && !accept_data_i) ;
        else begin
          if (m_full) m_ovr = 1;
          m_word = w; m_full = 1; e_valid = 1;
          e_irq = attn_en_i && w[8];
        end
      end
    end
    n_cmp++;
    if (rx_word_o !== m_word || rx_valid_o !== e_valid || attn_irq_o !== e_irq ||
        frame_err_o !== e_ferr || overrun_o !== m_ovr) begin
      n_bad++;
      $display("FAIL %s cyc %0d: actual word=%h v=%b irq=%b fe=%b ovr=%b expected word=%h v=%b irq=%b fe=%b ovr=%b",
               cur_req, cyc, rx_word_o, rx_valid_o, attn_irq_o, frame_err_o, overrun_o,
               m_word, e_valid, e_irq, e_ferr, m_ovr);
    end
  end

  task automatic send_frame(input logic [8:0] w, input logic stop,
                            input logic [10:0] gmask, input logic rd_end);
    @(negedge clk_i);
    q_due.push_back(cyc + 173);
    q_word.push_back(w);
    q_stop.push_back(stop);
    for (int i = 0; i < 176; i++) begin
      int   j;
      logic b;
      if (i > 0) @(negedge clk_i);
      j = i / 16;
      b = (j == 0) ? 1'b0 : (j == 10) ? stop : w[j-1];
      if (i % 16 == 8 && gmask[j]) b = ~b;
      rx_i = b;
      rd_i = rd_end && (i == 172);
    end
    @(negedge clk_i);
    rx_i = 1'b1; rd_i = 1'b0;
    repeat (20) @(negedge clk_i);
  endtask

  task automatic do_read();
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    cur_req = "R1/R7";                      // attention off: all words delivered
    send_frame(9'h0A5, 1, '0, 0); do_read();
    send_frame(9'h1C3, 1, '0, 0); do_read();

    cur_req = "R2";                         // single-sample glitches
    send_frame(9'h05A, 1, 11'b100_0000_1010, 0); do_read();

    cur_req = "R3";                         // false start then a good frame
    @(negedge clk_i); rx_i = 1'b0;
    repeat (3) @(negedge clk_i); rx_i = 1'b1;
    repeat (40) @(negedge clk_i);
    send_frame(9'h011, 1, '0, 0); do_read();

    cur_req = "R4";
    attn_en_i = 1'b1; accept_data_i = 1'b0;
    send_frame(9'h112, 1, '0, 0); do_read();
    cur_req = "R5";
    send_frame(9'h033, 1, '0, 0);
    cur_req = "R6";
    accept_data_i = 1'b1;
    send_frame(9'h044, 1, '0, 0); do_read();

    cur_req = "R8";
    send_frame(9'h0FF, 0, '0, 0);

    cur_req = "R9";
    send_frame(9'h101, 1, '0, 0);
    send_frame(9'h0C2, 1, '0, 0);
    do_read();

    cur_req = "R10";
    send_frame(9'h023, 1, '0, 0);
    send_frame(9'h0E4, 1, '0, 1);
    send_frame(9'h0E5, 1, '0, 0);           // overrun must follow
    do_read();

    cur_req = "R5";                         // dropped word leaves overrun low
    accept_data_i = 1'b0;
    send_frame(9'h1AA, 1, '0, 0);
    send_frame(9'h055, 1, '0, 0);
    do_read();

    repeat (10) @(negedge clk_i);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule